// File: doc/BRIEF.md
# TDM Channel Bus-Controller Sequencer

This block runs an external 8-bit parallel bus straight from the timing of a 2048 kbit/s time-division serial stream, with no processor in the loop. A bit clock at twice the bit rate and an active-low frame pulse drive a slot counter and a cycle-in-slot counter. From these counters the block sequences one external read and one external write in every valid timeslot. The read fetches the byte for the next channel. The write stores the byte that arrived in the previous channel.

Each slot is 16 clock cycles long. The first half belongs to this controller, and the block marks it with a start-of-slot strobe. The second half is left free for a second controller, and the block marks it with a delayed select strobe. A mode input chooses the channel plan. In the 32-channel plan every slot is valid. In the 24-channel plan every slot whose number is a multiple of four is skipped, and the remaining slots map in order onto buffer locations 0 to 23. The byte fetched by the read is held for the serial transmit path. The byte for the write is taken from the serial receive path.

Top module: `tdm_bus_seq`

## Requirements
- R1: At the first falling clock edge at which `frame_n` is low after it was high, the counters go to slot 0, cycle 0. Holding `frame_n` low for further cycles does not restart the counters.
- R2: Cycle-in-slot counts 0 to 15 on falling edges. The slot number counts 0 to 31 and wraps to 0 without a frame pulse.
- R3: In a valid slot with logical index n, `addr` carries the read address n+1 during cycles 0 to 3. `oe_n` is low only in cycles 1 and 2.
- R4: In the same slot, `addr` carries the write address n-1 during cycles 4 to 7. `we_n` is low only in cycles 5 and 6. At all other times `addr` is 0.
- R5: Addresses wrap within the plan. n+1 after the last index is 0, and n-1 from index 0 is the last index (31 or 23).
- R6: `stch_n` is low in cycles 0 to 7 of each valid slot. `dcs_n` is low in cycles 8 to 15. The two are never low together.
- R7: With `ch32`=0, slots 0, 4, 8 up to 28 are invalid and all strobes stay high in them. Slot s otherwise has index s - floor(s/4) - 1. With `ch32`=1 the index equals the slot number.
- R8: `rd_byte` takes `bus_din` at the rising edge inside cycle 2 while `oe_n` is low. At every other edge it holds its value.
- R9: `bus_dout` loads `rx_byte` at the falling edge that opens cycle 4. It then holds steady through the write.
- R10: While `cs_n` is high, `bus_drive` is 0 and `oe_n`/`we_n` stay high. While `cs_n` is low and the block is aligned, `bus_drive` is 1.
- R11: After reset and before the first frame pulse, `bus_drive`=0, `addr`=0 and all four strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two cycles per serial bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame pulse |
| ch32 | input | 1 | 1 = 32-channel plan, 0 = 24-channel plan |
| cs_n | input | 1 | Active-low chip select gating the bus |
| bus_din | input | DW | Data read from the external device |
| rx_byte | input | DW | Byte from the serial receive path to be written out |
| addr | output | 5 | External address |
| oe_n | output | 1 | Active-low output enable (read strobe) |
| we_n | output | 1 | Active-low write enable |
| stch_n | output | 1 | Active-low start-of-slot strobe, first half |
| dcs_n | output | 1 | Active-low delayed select strobe, second half |
| bus_drive | output | 1 | Pad drive enable for address, strobes and data |
| bus_dout | output | DW | Data driven during the write |
| rd_byte | output | DW | Last byte fetched, for the transmit path |

## Verification
Chip-select gating and read capture can fall on the same rising edge in cycle 2. The bench raises `cs_n` in cycle 2 of a valid slot and changes `bus_din` at the same time. It then expects `oe_n` high and `rd_byte` unchanged one cycle later. A frame pulse held low across several cycles is also driven. It must restart the counters only once, and this is judged from the read strobe appearing in cycles 1 and 2 after the restart.

// File: rtl/tdm_bus_seq.sv
module tdm_bus_seq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          ch32,
  input  logic          cs_n,
  input  logic [DW-1:0] bus_din,
  input  logic [DW-1:0] rx_byte,
  output logic [4:0]    addr,
  output logic          oe_n,
  output logic          we_n,
  output logic          stch_n,
  output logic          dcs_n,
  output logic          bus_drive,
  output logic [DW-1:0] bus_dout,
  output logic [DW-1:0] rd_byte
);
  localparam logic [3:0] LAST_CYC = 4'd15;
  localparam logic [4:0] TOP32 = 5'd31;
  localparam logic [4:0] TOP24 = 5'd23;

  logic          fp_q, synced;
  logic [3:0]    cyc;
  logic [4:0]    slot;
  logic [DW-1:0] wbuf;

  wire start = fp_q & ~frame_n;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q   <= 1'b1;
      synced <= 1'b0;
      cyc    <= '0;
      slot   <= '0;
      wbuf   <= '0;
    end else begin
      fp_q <= frame_n;
      if (start) begin
        cyc    <= '0;
        slot   <= '0;
        synced <= 1'b1;
      end else begin
        cyc <= cyc + 4'd1;
        if (cyc == LAST_CYC) slot <= slot + 5'd1;
        if (cyc == 4'd3) wbuf <= rx_byte;
      end
    end
  end

  wire       valid = synced & (ch32 | (slot[1:0] != 2'b00));
  wire [4:0] last  = ch32 ? TOP32 : TOP24;
  wire [4:0] idx   = ch32 ? slot : (slot - {2'b00, slot[4:2]} - 5'd1);
  wire [4:0] nxt   = (idx == last) ? 5'd0 : idx + 5'd1;
  wire [4:0] prv   = (idx == 5'd0) ? last : idx - 5'd1;
  wire       rd_win = valid & (cyc[3:2] == 2'b00);
  wire       wr_win = valid & (cyc[3:2] == 2'b01);
  wire       sel    = valid & ~cs_n;

  assign addr      = rd_win ? nxt : (wr_win ? prv : 5'd0);
  assign oe_n      = ~(sel & ((cyc == 4'd1) | (cyc == 4'd2)));
  assign we_n      = ~(sel & ((cyc == 4'd5) | (cyc == 4'd6)));
  assign stch_n    = ~(valid & ~cyc[3]);
  assign dcs_n     = ~(valid & cyc[3]);
  assign bus_drive = synced & ~cs_n;
  assign bus_dout  = wbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rd_byte <= '0;
    else if (!oe_n && cyc == 4'd2)   rd_byte <= bus_din;
  end
endmodule

// File: rtl/tdm_bus_seq_chk.sv
module tdm_bus_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          stch_n,
  input logic          dcs_n,
  input logic          bus_drive,
  input logic [DW-1:0] bus_dout,
  input logic [DW-1:0] rd_byte
);
  p_rw_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  p_oe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && $past(!oe_n)) |=> oe_n);

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |=> we_n);

  p_half_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!stch_n && !dcs_n));

  p_dcs_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dcs_n) |-> $past(!stch_n));

  p_wdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(bus_dout));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && $past(oe_n)) |-> $stable(rd_byte));

  p_cs_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!bus_drive && oe_n && we_n));
endmodule

bind tdm_bus_seq tdm_bus_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_tdm_bus_seq.sv
`timescale 1ns/1ps
module sim_tdm_bus_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1;
  logic ch32 = 1'b1;
  logic cs_n = 1'b0;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] rx_byte = 8'h00;
  logic [4:0] addr;
  logic oe_n, we_n, stch_n, dcs_n, bus_drive;
  logic [7:0] bus_dout, rd_byte;

  always #2 clk = ~clk;

  tdm_bus_seq #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ch32(ch32), .cs_n(cs_n),
    .bus_din(bus_din), .rx_byte(rx_byte), .addr(addr), .oe_n(oe_n),
    .we_n(we_n), .stch_n(stch_n), .dcs_n(dcs_n), .bus_drive(bus_drive),
    .bus_dout(bus_dout), .rd_byte(rd_byte)
  );

  int checks = 0;
  int failures = 0;
  int pos = 0;

  // {mode, position since frame start, addr, oe_n we_n stch_n dcs_n}
  localparam logic [20:0] VEC [18] = '{
    {1'b1, 11'd0,    5'd1,  4'b1101},
    {1'b1, 11'd1,    5'd1,  4'b0101},
    {1'b1, 11'd2,    5'd1,  4'b0101},
    {1'b1, 11'd4,    5'd31, 4'b1101},
    {1'b1, 11'd5,    5'd31, 4'b1001},
    {1'b1, 11'd8,    5'd0,  4'b1110},
    {1'b1, 11'd497,  5'd0,  4'b0101},
    {1'b1, 11'd502,  5'd30, 4'b1001},
    {1'b1, 11'd511,  5'd0,  4'b1110},
    {1'b0, 11'd512,  5'd0,  4'b1111},
    {1'b0, 11'd520,  5'd0,  4'b1111},
    {1'b0, 11'd529,  5'd1,  4'b0101},
    {1'b0, 11'd533,  5'd23, 4'b1001},
    {1'b0, 11'd585,  5'd0,  4'b1111},
    {1'b0, 11'd594,  5'd4,  4'b0101},
    {1'b0, 11'd1009, 5'd0,  4'b0101},
    {1'b0, 11'd1014, 5'd22, 4'b1001},
    {1'b0, 11'd1020, 5'd0,  4'b1110}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (pos %0d)", tag, act, exp, pos);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      pos++;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(3);
    // R11: idle before alignment
    chk("R11 bus_drive", bus_drive, 1'b0);
    chk("R11 addr", addr, 5'd0);
    chk("R11 strobes", {oe_n, we_n, stch_n, dcs_n}, 4'b1111);

    // R1: align
    frame_n = 1'b0;
    step(1);
    pos = 0;
    frame_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < 18; k++) begin
      ch32 = VEC[k][20];
      while (pos < int'(VEC[k][19:9])) step(1);
      #0.5;
      chk("R3 R4 R5 R7 addr", addr, VEC[k][8:4]);
      chk("R3 oe_n", oe_n, VEC[k][3]);
      chk("R4 we_n", we_n, VEC[k][2]);
      chk("R2 R6 R7 stch_n dcs_n", {stch_n, dcs_n}, VEC[k][1:0]);
    end

    // R1: resync mid-frame with a long-held pulse
    ch32 = 1'b1;
    step(2);
    frame_n = 1'b0;
    step(1);
    chk("R1 restart addr", addr, 5'd1);
    chk("R1 restart stch_n oe_n", {stch_n, oe_n}, 2'b01);
    step(1);
    chk("R1 held low cyc1 oe_n", oe_n, 1'b0);
    step(1);
    chk("R1 held low cyc2 oe_n", oe_n, 1'b0);
    step(1);
    chk("R1 held low cyc3 oe_n", oe_n, 1'b1);
    frame_n = 1'b1;

    // R8: read capture at cycle 2 (slot 1)
    step(14);
    bus_din = 8'h11;
    step(1);
    bus_din = 8'hA5;
    step(1);
    bus_din = 8'h3C;
    chk("R8 rd_byte", rd_byte, 8'hA5);

    // R9: write data captured at cycle-4 edge and held
    rx_byte = 8'h5A;
    step(1);
    rx_byte = 8'hFF;
    chk("R9 bus_dout cyc4", bus_dout, 8'h5A);
    step(2);
    chk("R9 bus_dout cyc6", bus_dout, 8'h5A);
    chk("R4 we_n cyc6", we_n, 1'b0);
    chk("R4 addr cyc6", addr, 5'd0);

    // R10: chip select gating (slot 2 cycle 1)
    step(11);
    cs_n = 1'b1;
    #0.5;
    chk("R10 deselect oe_n", oe_n, 1'b1);
    chk("R10 deselect bus_drive", bus_drive, 1'b0);
    cs_n = 1'b0;
    #0.5;
    chk("R10 select oe_n", oe_n, 1'b0);
    chk("R10 select bus_drive", bus_drive, 1'b1);
    // R8 R10: deselect on the capture cycle suppresses capture
    step(1);
    cs_n = 1'b1;
    bus_din = 8'h77;
    step(1);
    chk("R8 R10 gated capture", rd_byte, 8'hA5);
    cs_n = 1'b0;
    step(2);

    finish_run();
  end
endmodule